// File: doc/BRIEF.md
# CPU Next-Address Generator

This block forms the next memory address for an 8-bit processor core with a 16-bit address space. Every cycle the sequencer presents a 4-bit operation code, and the block chooses a base address and an offset from a set of sources. The sources are the memory address register, the program counter, the stack pointer, two operand bytes, the incoming data byte, the X and Y index bytes, and a branch condition. It then adds base and offset in one shared 16-bit adder.

The result is offered combinationally as the next address. It is registered into the memory address register (MAR) whenever the ready input is high. Operations that move the flow of control also load the program counter (PC). The previous PC value is kept in a delayed program counter (dPC).

A registered ready output goes low for exactly one cycle after any address that does not follow the previous one sequentially. This gives slow memory a wait state. The system normally feeds ready back to the ready input, optionally gated by an external stall. While reset is asserted, all three address registers take the vector presented on the vector input. Typical vectors are FFFC for reset, FFFE for the maskable interrupt and FFFA for the non-maskable interrupt.

Top module: `cpu_next_addr`

## Requirements
- R1: While reset is high, mar_o, pc_o, dpc_o and ao_o all equal vec_i, and rdy_o is 0.
- R2: On the first clock after reset is released, with rdy_i low, MAR keeps the vector and rdy_o becomes 1.
- R3: Operation codes select the next address: 0 gives MAR, 1 gives PC, 2 gives {8'h01, sp_i}, 3 gives {opb_i, opa_i}, 8 gives {8'h00, din_i}, 9 and 10 give {din_i, opa_i}, and 11 gives {din_i, opa_i}+1. This next address appears on nxt_o in the same cycle and is registered into MAR when rdy_i is 1.
- R4: Operation 4 (branch) gives MAR+1 plus din_i sign-extended to 16 bits when cond_i is 1, and MAR+1 when cond_i is 0.
- R5: Operations 12 (index X) and 14 (index Y) give {8'h00, (din_i + index) mod 256}, staying inside page zero.
- R6: Operations 13 (X) and 15 (Y) give {din_i, opa_i} plus the zero-extended index, with carry across all 16 bits.
- R7: Only operations 3, 4, 5, 9 and 11 load PC with the next address. All other operations leave pc_o and dpc_o unchanged.
- R8: Whenever PC loads, dpc_o takes the PC value from before that load.
- R9: After operations 0, 6 (MAR+1), 7 (MAR-1), 5 (PC+1) and a branch with cond_i 0, accepted with rdy_i 1, rdy_o is 1 on the next cycle.
- R10: After any other operation accepted with rdy_i 1, rdy_o is 0 for one cycle. After any cycle with rdy_i 0, rdy_o is 1.
- R11: Operation 5 gives PC+1, unless irq_i and brk_i are both 1. In that case the next address is PC itself, PC and dPC do not change, and the cycle counts as sequential. Either signal alone has no effect.
- R12: While rdy_i is 0, MAR, PC and dPC hold and ao_o shows MAR; nxt_o is still driven. While rdy_i is 1, ao_o equals nxt_o.
- R13: All address arithmetic wraps modulo 2^16 (MAR+1 from FFFF gives 0000; MAR-1 from 0000 gives FFFF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| vec_i | input | 16 | Vector loaded into MAR, PC and dPC during reset |
| brk_i | input | 1 | Break-vector flag; with irq_i it freezes the PC+1 step |
| irq_i | input | 1 | Interrupt pending |
| rdy_i | input | 1 | Ready; registers update only when 1 |
| op_i | input | 4 | Next-address operation code |
| cond_i | input | 1 | Branch condition |
| din_i | input | 8 | Data input byte |
| opa_i | input | 8 | Operand low byte |
| opb_i | input | 8 | Operand high byte |
| sp_i | input | 8 | Stack pointer |
| xidx_i | input | 8 | X index |
| yidx_i | input | 8 | Y index |
| ao_o | output | 16 | Address to memory bus |
| rdy_o | output | 1 | Ready; low for a one-cycle wait state |
| nxt_o | output | 16 | Combinational next address |
| mar_o | output | 16 | Memory address register |
| pc_o | output | 16 | Program counter |
| dpc_o | output | 16 | Delayed program counter |

## Verification
The assertions assume that every input is known and steady across each rising edge. They also assume that reset is high from time zero, so that the registers hold a defined vector before any property is evaluated. The wait-state properties assume that rdy_i is rdy_o gated by an external stall. Under that assumption, rdy_i is never 1 in the cycle after a non-sequential load. The bench builds rdy_i this way from a stall signal and changes inputs only on falling edges. It draws operation codes, operands, condition, stall and the interrupt/break pair at random, after a directed set of wrap, branch and freeze cases.

// File: rtl/cpu_next_addr_pkg.sv
package cpu_next_addr_pkg;
    localparam int AG_DW = 8;
    localparam int AG_AW = 2 * AG_DW;

    typedef enum logic [3:0] {
        OP_HOLD   = 4'h0,
        OP_PC     = 4'h1,
        OP_STACK  = 4'h2,
        OP_CALL   = 4'h3,
        OP_BRANCH = 4'h4,
        OP_STEP   = 4'h5,
        OP_INC    = 4'h6,
        OP_DEC    = 4'h7,
        OP_ZP     = 4'h8,
        OP_JUMP   = 4'h9,
        OP_ABS    = 4'hA,
        OP_RET    = 4'hB,
        OP_ZPX    = 4'hC,
        OP_ABSX   = 4'hD,
        OP_ZPY    = 4'hE,
        OP_ABSY   = 4'hF
    } ag_op_e;

    typedef struct packed {
        logic [AG_AW-1:0] mar;
        logic [AG_AW-1:0] pc;
        logic [AG_AW-1:0] dpc;
        logic             rdy;
    } ag_state_t;
endpackage

// File: rtl/cpu_next_addr_sum.sv
module cpu_next_addr_sum
    import cpu_next_addr_pkg::*;
(
    input  ag_op_e           op,
    input  logic             cond,
    input  logic             freeze,
    input  logic [AG_AW-1:0] mar,
    input  logic [AG_AW-1:0] pc,
    input  logic [AG_DW-1:0] din,
    input  logic [AG_DW-1:0] opa,
    input  logic [AG_DW-1:0] opb,
    input  logic [AG_DW-1:0] sp,
    input  logic [AG_DW-1:0] xidx,
    input  logic [AG_DW-1:0] yidx,
    output logic [AG_AW-1:0] na
);
    localparam logic [AG_DW-1:0] STACK_PAGE = AG_DW'(1);
    localparam logic [AG_DW-1:0] ZERO_PAGE  = '0;

    logic [AG_AW-1:0] base_d, off_d, sum_d;
    logic             cin_d, zp_d;
    logic [AG_AW-1:0] abs_w, zpb_w, rel_w, xw, yw;

    assign abs_w = {din, opa};
    assign zpb_w = {ZERO_PAGE, din};
    assign rel_w = {{AG_DW{din[AG_DW-1]}}, din};
    assign xw    = {ZERO_PAGE, xidx};
    assign yw    = {ZERO_PAGE, yidx};

    always_comb begin
        base_d = mar;
        off_d  = '0;
        cin_d  = 1'b0;
        zp_d   = 1'b0;
        unique case (op)
            OP_HOLD:   base_d = mar;
            OP_PC:     base_d = pc;
            OP_STACK:  base_d = {STACK_PAGE, sp};
            OP_CALL:   base_d = {opb, opa};
            OP_BRANCH: begin
                base_d = mar;
                off_d  = cond ? rel_w : '0;
                cin_d  = 1'b1;
            end
            OP_STEP: begin
                base_d = pc;
                cin_d  = ~freeze;
            end
            OP_INC: begin
                base_d = mar;
                cin_d  = 1'b1;
            end
            OP_DEC: begin
                base_d = mar;
                off_d  = '1;
            end
            OP_ZP:     base_d = zpb_w;
            OP_JUMP,
            OP_ABS:    base_d = abs_w;
            OP_RET: begin
                base_d = abs_w;
                cin_d  = 1'b1;
            end
            OP_ZPX: begin
                base_d = zpb_w;
                off_d  = xw;
                zp_d   = 1'b1;
            end
            OP_ABSX: begin
                base_d = abs_w;
                off_d  = xw;
            end
            OP_ZPY: begin
                base_d = zpb_w;
                off_d  = yw;
                zp_d   = 1'b1;
            end
            OP_ABSY: begin
                base_d = abs_w;
                off_d  = yw;
            end
            default: base_d = mar;
        endcase
        sum_d = base_d + off_d + {{(AG_AW-1){1'b0}}, cin_d};
        na    = zp_d ? {ZERO_PAGE, sum_d[AG_DW-1:0]} : sum_d;
    end
endmodule

// File: rtl/cpu_next_addr_class.sv
module cpu_next_addr_class
    import cpu_next_addr_pkg::*;
(
    input  ag_op_e op,
    input  logic   cond,
    input  logic   freeze,
    output logic   pc_load,
    output logic   seq
);
    always_comb begin
        pc_load = 1'b0;
        seq     = 1'b0;
        unique case (op)
            OP_HOLD, OP_INC, OP_DEC: seq = 1'b1;
            OP_STEP: begin
                seq     = 1'b1;
                pc_load = ~freeze;
            end
            OP_BRANCH: begin
                seq     = ~cond;
                pc_load = 1'b1;
            end
            OP_CALL, OP_JUMP, OP_RET: pc_load = 1'b1;
            default: begin
                pc_load = 1'b0;
                seq     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cpu_next_addr.sv
module cpu_next_addr
    import cpu_next_addr_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [15:0] vec_i,
    input  logic        brk_i,
    input  logic        irq_i,
    input  logic        rdy_i,
    input  logic [3:0]  op_i,
    input  logic        cond_i,
    input  logic [7:0]  din_i,
    input  logic [7:0]  opa_i,
    input  logic [7:0]  opb_i,
    input  logic [7:0]  sp_i,
    input  logic [7:0]  xidx_i,
    input  logic [7:0]  yidx_i,
    output logic [15:0] ao_o,
    output logic        rdy_o,
    output logic [15:0] nxt_o,
    output logic [15:0] mar_o,
    output logic [15:0] pc_o,
    output logic [15:0] dpc_o
);
    ag_state_t        st_d, st_q;
    ag_op_e           op_w;
    logic             freeze_w, pc_load_w, seq_w;
    logic [AG_AW-1:0] na_w;

    assign op_w     = ag_op_e'(op_i);
    assign freeze_w = irq_i & brk_i;

    cpu_next_addr_sum u_sum (
        .op(op_w), .cond(cond_i), .freeze(freeze_w),
        .mar(st_q.mar), .pc(st_q.pc), .din(din_i), .opa(opa_i), .opb(opb_i),
        .sp(sp_i), .xidx(xidx_i), .yidx(yidx_i), .na(na_w)
    );

    cpu_next_addr_class u_class (
        .op(op_w), .cond(cond_i), .freeze(freeze_w),
        .pc_load(pc_load_w), .seq(seq_w)
    );

    always_comb begin
        st_d = st_q;
        if (rdy_i) begin
            st_d.mar = na_w;
            st_d.rdy = seq_w;
            if (pc_load_w) begin
                st_d.pc  = na_w;
                st_d.dpc = st_q.pc;
            end
        end else begin
            st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '{mar: vec_i, pc: vec_i, dpc: vec_i, rdy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_o = na_w;
    assign ao_o  = rdy_i ? na_w : st_q.mar;
    assign mar_o = st_q.mar;
    assign pc_o  = st_q.pc;
    assign dpc_o = st_q.dpc;
    assign rdy_o = st_q.rdy;

    a_r12_stall_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        !rdy_i |=> ($stable(mar_o) && $stable(pc_o) && $stable(dpc_o) && rdy_o));

    a_r8_dpc_takes_old_pc: assert property (@(posedge clk_i) disable iff (rst_i)
        (pc_o != $past(pc_o)) |-> (dpc_o == $past(pc_o)));

    a_r7_mar_only_ops: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdy_i && !(op_i inside {4'h3, 4'h4, 4'h5, 4'h9, 4'hB}))
        |=> ($stable(pc_o) && $stable(dpc_o)));

    a_r11_freeze_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdy_i && op_i == 4'h5 && irq_i && brk_i)
        |=> (mar_o == $past(pc_o) && $stable(pc_o) && $stable(dpc_o) && rdy_o));

    a_r5_zero_page: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdy_i && (op_i == 4'hC || op_i == 4'hE)) |=> (mar_o[15:8] == 8'h00));

    a_r9_sequential_ready: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdy_i && (op_i == 4'h0 || op_i == 4'h6 || op_i == 4'h7)) |=> rdy_o);

    a_r10_jump_waits: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdy_i && (op_i == 4'h9 || op_i == 4'hA || op_i == 4'h2)) |=> !rdy_o);
endmodule

// File: tb/cpu_next_addr_tb_top.sv
`timescale 1ns/1ps
module cpu_next_addr_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] vec = 16'hFFFC;
    logic        brk = 0, irq = 0, cond = 0, stall = 0;
    logic [3:0]  op = 4'h0;
    logic [7:0]  din = 0, opa = 0, opb = 0, sp = 8'hFF, xi = 0, yi = 0;
    logic        rdy_in;
    logic [15:0] ao, nxt, mar, pc, dpc;
    logic        rdy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    int m_mar, m_pc, m_dpc;
    bit m_rdy;
    bit first_after_rst;

    always #2.5 clk = ~clk;

    assign rdy_in = rdy & ~stall;

    cpu_next_addr dut_i (
        .clk_i(clk), .rst_i(rst), .vec_i(vec), .brk_i(brk), .irq_i(irq),
        .rdy_i(rdy_in), .op_i(op), .cond_i(cond), .din_i(din), .opa_i(opa),
        .opb_i(opb), .sp_i(sp), .xidx_i(xi), .yidx_i(yi),
        .ao_o(ao), .rdy_o(rdy), .nxt_o(nxt), .mar_o(mar), .pc_o(pc), .dpc_o(dpc)
    );

    function automatic int model_na();
        int r;
        int rel;
        rel = (din >= 128) ? int'(din) - 256 : int'(din);
        case (op)
            4'h0: r = m_mar;
            4'h1: r = m_pc;
            4'h2: r = 256 + sp;
            4'h3: r = opb * 256 + opa;
            4'h4: r = m_mar + 1 + (cond ? rel : 0);
            4'h5: r = (irq && brk) ? m_pc : m_pc + 1;
            4'h6: r = m_mar + 1;
            4'h7: r = m_mar - 1;
            4'h8: r = din;
            4'h9, 4'hA: r = din * 256 + opa;
            4'hB: r = din * 256 + opa + 1;
            4'hC: r = (din + xi) % 256;
            4'hD: r = din * 256 + opa + xi;
            4'hE: r = (din + yi) % 256;
            default: r = din * 256 + opa + yi;
        endcase
        return (r + 65536) % 65536;
    endfunction

    function automatic bit model_pc_load();
        return (op == 4'h3) || (op == 4'h4) || (op == 4'h9) || (op == 4'hB)
            || (op == 4'h5 && !(irq && brk));
    endfunction

    function automatic bit model_seq();
        return (op == 4'h0) || (op == 4'h6) || (op == 4'h7) || (op == 4'h5)
            || (op == 4'h4 && !cond);
    endfunction

    string mar_tag = "R1";

    always @(posedge clk) begin
        bit rin;
        int na;
        if (rst) begin
            m_mar = vec; m_pc = vec; m_dpc = vec; m_rdy = 0;
            mar_tag = "R1";
        end else begin
            rin = m_rdy && !stall;
            na  = model_na();
            if (rin) begin
                if (model_pc_load()) begin
                    m_dpc = m_pc;
                    m_pc  = na;
                end
                m_mar = na;
                m_rdy = model_seq();
                case (op)
                    4'h4: mar_tag = "R4";
                    4'h5: mar_tag = (irq && brk) ? "R11" : "R3";
                    4'h6, 4'h7: mar_tag = "R13";
                    4'hC, 4'hE: mar_tag = "R5";
                    4'hD, 4'hF: mar_tag = "R6";
                    default: mar_tag = "R3";
                endcase
            end else begin
                m_rdy = 1;
                mar_tag = first_after_rst ? "R2" : "R12";
            end
            first_after_rst = 0;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit rin;
        int na;
        rin = m_rdy && !stall;
        na  = model_na();
        chk(mar_tag, "mar", int'(mar), m_mar);
        chk(rst ? "R1" : "R7", "pc", int'(pc), m_pc);
        chk(rst ? "R1" : "R8", "dpc", int'(dpc), m_dpc);
        chk(rst ? "R1" : (m_rdy ? "R9" : "R10"), "rdy", int'(rdy), int'(m_rdy));
        chk("R3", "nxt", int'(nxt), na);
        chk(rst ? "R1" : "R12", "ao", int'(ao), rin ? na : m_mar);
    endtask

    task automatic step(input logic [3:0] o, input logic [7:0] d, input logic [7:0] a,
                        input logic [7:0] b, input logic c);
        op = o; din = d; opa = a; opb = b; cond = c;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(input logic [15:0] v);
        @(negedge clk);
        rst = 1; vec = v; op = 4'h0; stall = 0;
        @(posedge clk);
        @(negedge clk);
        compare_all();   // R1 reset state
        rst = 0;
        first_after_rst = 1;
        step(4'h0, 8'h00, 8'h00, 8'h00, 0);   // R2 first clock after release
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        xi = 8'h69; yi = 8'h6A;
        do_reset(16'hFFFC);
        // R13 wrap up and down
        step(4'h6, 0, 0, 0, 0); step(4'h6, 0, 0, 0, 0); step(4'h6, 0, 0, 0, 0);
        step(4'h6, 0, 0, 0, 0); step(4'h6, 0, 0, 0, 0);
        step(4'h7, 0, 0, 0, 0); step(4'h7, 0, 0, 0, 0);
        // R3 direct forms with wait states
        step(4'h1, 0, 0, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'h2, 0, 0, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'h3, 0, 8'h5A, 8'hA5, 0); step(4'h0, 0, 0, 0, 0);
        // R4 branch backward taken, not taken
        step(4'h4, 8'h96, 0, 0, 1); step(4'h0, 0, 0, 0, 0);
        step(4'h4, 8'h96, 0, 0, 0);
        step(4'h4, 8'h7F, 0, 0, 1); step(4'h0, 0, 0, 0, 0);
        // R11 step, then freeze cases
        step(4'h5, 0, 0, 0, 0);
        irq = 1; step(4'h5, 0, 0, 0, 0);
        irq = 0; brk = 1; step(4'h5, 0, 0, 0, 0);
        irq = 1; step(4'h5, 0, 0, 0, 0); step(4'h5, 0, 0, 0, 0);
        irq = 0; brk = 0;
        // R5 R6 index modes incl. carry
        step(4'hC, 8'hF0, 0, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'hE, 8'h96, 0, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'hD, 8'h12, 8'hF0, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'hF, 8'hFF, 8'hFF, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'h8, 8'h33, 0, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'h9, 8'h40, 8'h10, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'hA, 8'h41, 8'h11, 0, 0); step(4'h0, 0, 0, 0, 0);
        step(4'hB, 8'h42, 8'hFF, 0, 0); step(4'h0, 0, 0, 0, 0);
        // R12 external stall
        stall = 1; step(4'h9, 8'h77, 8'h00, 0, 0); step(4'h6, 0, 0, 0, 0);
        stall = 0; step(4'h6, 0, 0, 0, 0);
        // R1 reset with another vector
        do_reset(16'hFFFA);
        for (int i = 0; i < 3000; i++) begin
            irq   = ($urandom % 4) == 0;
            brk   = ($urandom % 3) == 0;
            stall = ($urandom % 5) == 0;
            sp = 8'($urandom); xi = 8'($urandom); yi = 8'($urandom);
            step(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        end
        do_reset(16'hFFFE);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule